// File: doc/BRIEF.md
# Serial-Address Byte Programming Port

This block is the device-side access path an external programmer uses to load and read back an on-chip byte memory that has no address pins. A four-bit mode input picks one of four operations: reset the address to zero, write, verify, or inhibit. Rising edges on a separate programming clock input step an internal address counter, one address per four edges. Each byte crosses the boundary as two nibbles on two 4-bit data ports, each port having its own input, output and output-enable lines.

A single qualifier input, `prog_en`, stands for the condition that programming supplies are present. While it is low, the block behaves as if inhibit were selected and does not move the counter. The array is a synchronous behavioural model held inside the block, sized by `DEPTH`, which defaults to 8064 bytes. The programming clock is sampled by the system clock `clk`, so each of its high and low phases must last at least one `clk` period.

Top module: `prom_prog_port`

## Requirements
- R1: After reset both output enables are 0, `ovf` is 0 and the internal address is 0.
- R2: `mode_sel` codes are 4'b0001 clear, 4'b0010 write, 4'b0011 verify, 4'b0000 inhibit. Every other code acts as inhibit: no write and no port drive.
- R3: Outside clear mode, and with `prog_en` high, the address rises by one on every fourth rising edge of `pclk`. The first three edges of a group leave it unchanged.
- R4: In write mode, the byte {`hi_in`, `lo_in`} (bits 7..4 from the upper port, bits 3..0 from the lower port) is stored at the current address on the first `pclk` rising edge of each four-edge group. Later data in the same group is not stored.
- R5: In verify mode, one `clk` after the mode or address settles, both output enables are 1. `hi_out` carries bits 7..4 and `lo_out` carries bits 3..0 of the byte at the current address.
- R6: In inhibit mode both output enables are 0 and `pclk` edges store nothing, although they still step the address.
- R7: While `prog_en` is low, no mode has any effect: the ports are not driven, nothing is written, and neither the address nor the edge count moves.
- R8: The address saturates at `DEPTH`-1. A fourth edge at that address sets `ovf`, which stays set until clear mode or reset.
- R9: Clear mode (with `prog_en` high) forces the address and the edge count to 0 and clears `ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_en | input | 1 | Programming supplies present qualifier |
| mode_sel | input | 4 | Operation select code |
| pclk | input | 1 | Programming clock; every fourth rising edge steps the address |
| lo_in | input | 4 | Lower data port, input side (bits 3..0) |
| hi_in | input | 4 | Upper data port, input side (bits 7..4) |
| lo_out | output | 4 | Lower data port, output side |
| hi_out | output | 4 | Upper data port, output side |
| lo_oe | output | 1 | Lower port output enable |
| hi_oe | output | 1 | Upper port output enable |
| ovf | output | 1 | Sticky flag: stepped past the last address |

## Verification
The assertions assume that `pclk` is held at 0 through reset. They also assume that each level of `pclk` lasts at least one `clk` period, so that each rising edge is seen exactly once. The bench toggles `pclk` on falling `clk` edges and keeps every level for two `clk` periods. It changes `mode_sel`, `prog_en` and the data only between pulses, never during a four-edge group, except for the one deliberate data change that tests R4. It runs the block at a small depth so that the whole address range, including saturation, is swept.

// File: rtl/prom_prog_pkg.sv
package prom_prog_pkg;

   typedef enum logic [1:0] {
      OP_INHIBIT = 2'd0,
      OP_CLEAR   = 2'd1,
      OP_WRITE   = 2'd2,
      OP_VERIFY  = 2'd3
   } prog_op_e;

   localparam logic [3:0] CODE_INHIBIT = 4'b0000;
   localparam logic [3:0] CODE_CLEAR   = 4'b0001;
   localparam logic [3:0] CODE_WRITE   = 4'b0010;
   localparam logic [3:0] CODE_VERIFY  = 4'b0011;

   localparam int NIBBLE_W = 4;
   localparam int BYTE_W   = 2 * NIBBLE_W;

endpackage

// File: rtl/prom_mode_decode.sv
module prom_mode_decode
   import prom_prog_pkg::*;
#(
   parameter int MODE_W = 4
) (
   input  logic              prog_en,
   input  logic [MODE_W-1:0] mode_sel,
   output prog_op_e          op
);

   generate
      if (MODE_W != 4) begin : g_bad_mode_w
         $error("prom_mode_decode: MODE_W must be 4");
      end
   endgenerate

   // Undefined codes and a low qualifier both fall back to inhibit (R2, R7)
   always_comb begin
      op = OP_INHIBIT;
      if (prog_en) begin
         unique case (mode_sel)
            CODE_CLEAR:  op = OP_CLEAR;
            CODE_WRITE:  op = OP_WRITE;
            CODE_VERIFY: op = OP_VERIFY;
            default:     op = OP_INHIBIT;
         endcase
      end
   end

endmodule

// File: rtl/prom_addr_ctr.sv
module prom_addr_ctr #(
   parameter int DEPTH  = 8064,
   parameter int PULSES = 4,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = (PULSES > 1) ? $clog2(PULSES) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pclk,
   input  logic          adv_en,
   input  logic          clr,
   output logic [AW-1:0] addr,
   output logic          first_rise,
   output logic          ovf
);

   localparam logic [AW-1:0] LAST      = AW'(DEPTH - 1);
   localparam logic [PW-1:0] PHASE_TOP = PW'(PULSES - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("prom_addr_ctr: DEPTH must be at least 2");
      end
      if (PULSES < 2) begin : g_bad_pulses
         $error("prom_addr_ctr: PULSES must be at least 2");
      end
   endgenerate

   logic          pclk_q;
   logic          rise;
   logic [PW-1:0] phase_q;
   logic [AW-1:0] addr_q;
   logic          ovf_q;

   assign rise = pclk & ~pclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pclk_q  <= 1'b0;
         phase_q <= '0;
         addr_q  <= '0;
         ovf_q   <= 1'b0;
      end else begin
         pclk_q <= pclk;
         if (clr) begin
            phase_q <= '0;
            addr_q  <= '0;
            ovf_q   <= 1'b0;
         end else if (adv_en && rise) begin
            if (phase_q == PHASE_TOP) begin
               phase_q <= '0;
               if (addr_q == LAST) begin
                  ovf_q <= 1'b1;
               end else begin
                  addr_q <= addr_q + AW'(1);
               end
            end else begin
               phase_q <= phase_q + PW'(1);
            end
         end
      end
   end

   assign addr       = addr_q;
   assign ovf        = ovf_q;
   assign first_rise = adv_en && !clr && rise && (phase_q == '0);

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !clr && rise && phase_q == PHASE_TOP && addr_q != LAST)
         |=> addr_q == $past(addr_q) + AW'(1));

   assert_hold_mid_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && phase_q != PHASE_TOP) |=> $stable(addr_q));

   assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      addr_q <= LAST);

   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr) |=> ovf_q);

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (addr_q == '0 && !ovf_q));

endmodule

// File: rtl/prom_array.sv
module prom_array #(
   parameter int DEPTH = 8064,
   parameter bit PACK2 = 1'b1,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);

   generate
      if (PACK2) begin : g_pair
         localparam int WORDS = DEPTH / 2;

         if ((DEPTH % 2) != 0) begin : g_bad_odd
            $error("prom_array: DEPTH must be even when PACK2 is set");
         end

         logic [15:0]   mem [WORDS];
         logic [15:0]   word_q;
         logic          lane_q;
         logic [AW-2:0] widx;

         assign widx = addr[AW-1:1];

         always_ff @(posedge clk) begin
            if (we) begin
               if (addr[0]) begin
                  mem[widx][15:8] <= wdata;
               end else begin
                  mem[widx][7:0] <= wdata;
               end
            end
            word_q <= mem[widx];
            lane_q <= addr[0];
         end

         assign rdata = lane_q ? word_q[15:8] : word_q[7:0];
      end else begin : g_byte
         logic [7:0] mem [DEPTH];
         logic [7:0] byte_q;

         always_ff @(posedge clk) begin
            if (we) begin
               mem[addr] <= wdata;
            end
            byte_q <= mem[addr];
         end

         assign rdata = byte_q;
      end
   endgenerate

endmodule

// File: rtl/prom_nibble_port.sv
module prom_nibble_port
   import prom_prog_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                drive,
   input  logic [BYTE_W-1:0]   rdata,
   input  logic [NIBBLE_W-1:0] lo_in,
   input  logic [NIBBLE_W-1:0] hi_in,
   output logic [BYTE_W-1:0]   wdata,
   output logic [NIBBLE_W-1:0] lo_out,
   output logic [NIBBLE_W-1:0] hi_out,
   output logic                lo_oe,
   output logic                hi_oe
);

   logic oe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_q <= 1'b0;
      end else begin
         oe_q <= drive;
      end
   end

   // Upper port carries bits 7..4, lower port bits 3..0 (R4, R5)
   assign wdata  = {hi_in, lo_in};
   assign hi_out = rdata[BYTE_W-1:NIBBLE_W];
   assign lo_out = rdata[NIBBLE_W-1:0];
   assign lo_oe  = oe_q;
   assign hi_oe  = oe_q;

endmodule

// File: rtl/prom_prog_port.sv
module prom_prog_port
   import prom_prog_pkg::*;
#(
   parameter int DEPTH  = 8064,
   parameter int PULSES = 4,
   parameter bit PACK2  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       prog_en,
   input  logic [3:0] mode_sel,
   input  logic       pclk,
   input  logic [3:0] lo_in,
   input  logic [3:0] hi_in,
   output logic [3:0] lo_out,
   output logic [3:0] hi_out,
   output logic       lo_oe,
   output logic       hi_oe,
   output logic       ovf
);

   localparam int AW = $clog2(DEPTH);

   prog_op_e      op;
   logic          clr;
   logic          adv_en;
   logic          first_rise;
   logic          we;
   logic [AW-1:0] addr;
   logic [7:0]    wdata;
   logic [7:0]    rdata;

   prom_mode_decode #(.MODE_W(4)) u_decode (
      .prog_en  (prog_en),
      .mode_sel (mode_sel),
      .op       (op)
   );

   assign clr    = (op == OP_CLEAR);
   assign adv_en = prog_en && (op != OP_CLEAR);
   assign we     = first_rise && (op == OP_WRITE);

   prom_addr_ctr #(.DEPTH(DEPTH), .PULSES(PULSES)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .pclk       (pclk),
      .adv_en     (adv_en),
      .clr        (clr),
      .addr       (addr),
      .first_rise (first_rise),
      .ovf        (ovf)
   );

   prom_array #(.DEPTH(DEPTH), .PACK2(PACK2)) u_array (
      .clk   (clk),
      .we    (we),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata)
   );

   prom_nibble_port u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .drive  (op == OP_VERIFY),
      .rdata  (rdata),
      .lo_in  (lo_in),
      .hi_in  (hi_in),
      .wdata  (wdata),
      .lo_out (lo_out),
      .hi_out (hi_out),
      .lo_oe  (lo_oe),
      .hi_oe  (hi_oe)
   );

   assert_write_only_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (prog_en && mode_sel == CODE_WRITE));

   assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_en |=> (!lo_oe && !hi_oe));

   assert_verify_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_en && mode_sel == CODE_VERIFY) |=> (lo_oe && hi_oe));

   assert_other_codes_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel != CODE_VERIFY) |=> (!lo_oe && !hi_oe));

endmodule

// File: tb/test_prom_prog_port.sv
module test_prom_prog_port;

   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prog_en = 1'b0;
   logic [3:0] mode_sel = 4'b0000;
   logic       pclk = 1'b0;
   logic [3:0] lo_in = 4'h0;
   logic [3:0] hi_in = 4'h0;
   logic [3:0] lo_out;
   logic [3:0] hi_out;
   logic       lo_oe;
   logic       hi_oe;
   logic       ovf;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   prom_prog_port #(.DEPTH(DEPTH)) i_prom_prog_port (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .mode_sel(mode_sel),
      .pclk(pclk), .lo_in(lo_in), .hi_in(hi_in), .lo_out(lo_out),
      .hi_out(hi_out), .lo_oe(lo_oe), .hi_oe(hi_oe), .ovf(ovf)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 29 + 7) & 255);
   endfunction

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse();
      @(negedge clk) pclk = 1'b1;
      idle(2);
      pclk = 1'b0;
      idle(2);
   endtask

   task automatic group();
      repeat (4) pulse();
   endtask

   task automatic set_mode(logic [3:0] m);
      @(negedge clk) mode_sel = m;
      idle(3);
   endtask

   task automatic put(logic [7:0] b);
      hi_in = b[7:4];
      lo_in = b[3:0];
   endtask

   function automatic int port_byte();
      return {hi_out, lo_out};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(2);
      // R1: reset state
      chk("R1 lo_oe", lo_oe, 0);
      chk("R1 hi_oe", hi_oe, 0);
      chk("R1 ovf", ovf, 0);
      prog_en = 1'b1;
      set_mode(4'b0011);
      chk("R1 address 0 after reset", lo_oe && hi_oe, 1);

      // R4: write sweep; data changed after the first edge must not land
      set_mode(4'b0001);
      set_mode(4'b0010);
      for (int a = 0; a < DEPTH; a++) begin
         put(pat(a));
         pulse();
         put(~pat(a));
         repeat (3) pulse();
      end
      idle(2);
      chk("R8 ovf after stepping past last", ovf, 1);
      set_mode(4'b0000);
      chk("R8 ovf sticky", ovf, 1);
      chk("R6 inhibit lo_oe", lo_oe, 0);
      chk("R6 inhibit hi_oe", hi_oe, 0);
      set_mode(4'b0011);
      chk("R8 saturated at last address", port_byte(), pat(DEPTH - 1));

      // R9: clear
      set_mode(4'b0001);
      chk("R9 ovf cleared", ovf, 0);
      set_mode(4'b0011);

      // R5, R4: verify sweep
      for (int a = 0; a < DEPTH; a++) begin
         chk("R5 oe", lo_oe && hi_oe, 1);
         chk($sformatf("R4 R5 byte at %0d", a), port_byte(), pat(a));
         group();
         idle(1);
      end

      // R3: three edges hold, fourth steps
      set_mode(4'b0001);
      set_mode(4'b0011);
      repeat (3) pulse();
      idle(1);
      chk("R3 held after three edges", port_byte(), pat(0));
      pulse();
      idle(1);
      chk("R3 stepped on fourth edge", port_byte(), pat(1));

      // R6: inhibit stores nothing at address 1 but steps to 2
      set_mode(4'b0000);
      put(8'hA5);
      group();
      // R2: undefined code 4'b1010 at address 2
      set_mode(4'b1010);
      chk("R2 undefined code lo_oe", lo_oe, 0);
      chk("R2 undefined code hi_oe", hi_oe, 0);
      put(8'h5A);
      group();
      set_mode(4'b0001);
      set_mode(4'b0011);
      group();
      idle(1);
      chk("R6 inhibit left byte 1", port_byte(), pat(1));
      group();
      idle(1);
      chk("R2 undefined code left byte 2", port_byte(), pat(2));

      // R7: qualifier low, write code, pulses: no write, no step
      @(negedge clk) prog_en = 1'b0;
      idle(2);
      chk("R7 disabled lo_oe", lo_oe, 0);
      chk("R7 disabled hi_oe", hi_oe, 0);
      set_mode(4'b0010);
      put(8'h3C);
      group();
      set_mode(4'b0001);
      set_mode(4'b0011);
      @(negedge clk) prog_en = 1'b1;
      idle(3);
      chk("R7 no write and no step", port_byte(), pat(2));
      // R7: edge count did not advance while disabled
      repeat (3) pulse();
      idle(1);
      chk("R7 edge count held", port_byte(), pat(2));
      pulse();
      idle(1);
      chk("R3 step after enable", port_byte(), pat(3));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule